// File: doc/BRIEF.md
# Single-Precision Multiply Special-Operand Stage

This block sits in front of the arithmetic core of a single-precision floating-point multiplier. It takes two binary32 operands, sorts each into zero, subnormal, normal, infinity, quiet NaN or signaling NaN, and decides whether the product is settled before any multiplication happens. Settled cases are NaN propagation, infinity, signed zero and the invalid infinity-times-zero case. For those, the block returns the final 32-bit result together with an invalid flag. When invalid trapping is enabled it returns a trap request instead, and no result.

When both operands are finite and nonzero, the block hands the core two 24-bit significands with the leading one in bit 23, plus a signed 10-bit intermediate exponent. Subnormal inputs are normalized with a leading-one search, and the exponent is reduced to match.

The decision logic is combinational. One register stage with a valid/ready handshake sits at the output.
- An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `fpm_special_stage`

## Requirements
- R1: The result sign `res_sign` equals bit 31 of `op_a` XOR bit 31 of `op_b`. Within a binary32 word, bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction.
- R2: Infinity times zero, in either order, with `trap_en` low gives:
  - `invalid` = 1 and `early_valid` = 1;
  - `early_res` = the default quiet NaN 0x7FC00000 with its bit 31 replaced by the R1 sign.
- R3: Any invalid case with `trap_en` high gives `trap_req` = 1, `invalid` = 0 and `early_valid` = 0. The invalid cases are infinity times zero and any signaling NaN operand.
- R4: Infinity times an operand that is neither NaN nor zero gives `early_res` = infinity (exponent all ones, fraction zero) carrying the R1 sign.
- R5: A NaN in `op_a` is handled as follows. A NaN is quieted by setting fraction bit 22. Each signaling case sets `invalid` (or `trap_req` under R3).
  - A signaling `op_a` is returned quieted.
  - Otherwise, a signaling `op_b` is returned quieted.
  - Otherwise `op_a` is returned unchanged.
- R6: When `op_a` is not a NaN (including when it is infinity) and `op_b` is a NaN, `op_b` is returned. It is quieted, with invalid raised, if it was signaling.
- R7: A zero operand with a finite other operand gives `early_res` = signed zero (R1 sign, all other bits zero), with `invalid` = 0.
- R8: When both operands are normal, `early_valid`, `invalid` and `trap_req` are 0. Each significand output is {1, fraction}, and `res_exp` = expA + expB − 127 as a signed 10-bit value.
- R9: For a subnormal operand, the significand is the fraction shifted left until its leading one reaches bit 23. That operand contributes 1 − s to `res_exp` in place of its exponent field, where s is the shift count.
- R10: While `out_valid` = 1 and `out_ready` = 0, every output stays stable and `in_ready` = 0. After `out_ready` = 1, `out_valid` falls on the next edge unless a new pair is accepted.
- R11: After reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Stage can accept a pair |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| trap_en | input | 1 | Invalid-trap enable, sampled with the operands |
| out_valid | output | 1 | Output register holds a decision |
| out_ready | input | 1 | Downstream accepts the decision |
| res_sign | output | 1 | XOR of operand signs |
| early_valid | output | 1 | Result settled without arithmetic |
| early_res | output | 32 | Settled result |
| invalid | output | 1 | Invalid operation flagged (trap disabled) |
| trap_req | output | 1 | Invalid operation with trap enabled |
| sig_a | output | 24 | Normalized significand of op_a |
| sig_b | output | 24 | Normalized significand of op_b |
| res_exp | output | 10 | Signed intermediate exponent |

## Verification
The hardest situations to reach are the NaN priority pairs: a quiet NaN in the first operand against a signaling NaN in the second, and infinity against a NaN. Also hard to reach are subnormals whose single set bit is the lowest fraction bit, which need the longest normalization shift. Uniformly random 32-bit words almost never produce these cases. The stimulus therefore first draws an operand class and then builds a word of that class, so each class pairing appears often. Directed pairs cover these orderings under both trap settings, along with the extreme exponents.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  parameter int EXP_W  = 8;
  parameter int MAN_W  = 23;
  parameter int IEXP_W = 10;
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } opclass_e;

  function automatic logic is_nan(opclass_e c);
    return (c == CL_QNAN) || (c == CL_SNAN);
  endfunction
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] word,
  output opclass_e       cls
);
  logic [EW-1:0] ex;
  logic [MW-1:0] fr;
  assign ex = word[EW+MW-1:MW];
  assign fr = word[MW-1:0];

  always_comb begin
    if (ex == '0)
      cls = (fr == '0) ? CL_ZERO : CL_SUB;
    else if (ex == '1) begin
      if (fr == '0)        cls = CL_INF;
      else if (fr[MW-1])   cls = CL_QNAN;
      else                 cls = CL_SNAN;
    end else
      cls = CL_NORM;
  end
endmodule

// File: rtl/fpm_subnorm.sv
module fpm_subnorm #(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int XW = 10
) (
  input  logic [EW-1:0]        ex_field,
  input  logic [MW-1:0]        frac,
  output logic [MW:0]          sig,
  output logic signed [XW-1:0] ex_part
);
  localparam int PW = $clog2(MW + 2);

  logic [PW-1:0] top_pos;
  logic [PW-1:0] shamt;

  // leading-one search: highest set fraction bit wins
  always_comb begin
    top_pos = '0;
    for (int i = 0; i < MW; i++)
      if (frac[i]) top_pos = PW'(i);
  end

  assign shamt = PW'(MW) - top_pos;

  always_comb begin
    if (ex_field != '0) begin
      sig     = {1'b1, frac};
      ex_part = $signed({{(XW-EW){1'b0}}, ex_field});
    end else begin
      sig     = {1'b0, frac} << shamt;
      ex_part = XW'(1) - $signed({{(XW-PW){1'b0}}, shamt});
    end
  end
endmodule

// File: rtl/fpm_decide.sv
module fpm_decide
  import fpm_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] a,
  input  logic [EW+MW:0] b,
  input  opclass_e       ca,
  input  opclass_e       cb,
  input  logic           sgn,
  input  logic           trap_en,
  output logic           early,
  output logic [EW+MW:0] res,
  output logic           inval,
  output logic           trap
);
  localparam int WW = EW + MW + 1;
  localparam logic [WW-1:0] QBIT = WW'(1) << (MW - 1);

  logic [WW-1:0] inf_w, zero_w, dnan_w;
  logic          done, hit, settled;

  assign inf_w  = {sgn, {EW{1'b1}}, {MW{1'b0}}};
  assign zero_w = {sgn, {(WW-1){1'b0}}};
  assign dnan_w = {sgn, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  always_comb begin
    done    = 1'b0;
    hit     = 1'b0;
    settled = 1'b0;
    res     = '0;
    // first operand takes precedence
    if (ca == CL_INF && !is_nan(cb)) begin
      done = 1'b1;
      if (cb == CL_ZERO) begin hit = 1'b1; res = dnan_w; end
      else begin settled = 1'b1; res = inf_w; end
    end else if (is_nan(ca)) begin
      done = 1'b1;
      if (ca == CL_SNAN)      begin hit = 1'b1; res = a | QBIT; end
      else if (cb == CL_SNAN) begin hit = 1'b1; res = b | QBIT; end
      else begin settled = 1'b1; res = a; end
    end
    if (!done) begin
      if (cb == CL_INF) begin
        if (ca == CL_ZERO) begin hit = 1'b1; res = dnan_w; end
        else begin settled = 1'b1; res = inf_w; end
      end else if (is_nan(cb)) begin
        if (cb == CL_SNAN) begin hit = 1'b1; res = b | QBIT; end
        else begin settled = 1'b1; res = b; end
      end else if (ca == CL_ZERO || cb == CL_ZERO) begin
        settled = 1'b1;
        res     = zero_w;
      end
    end
  end

  assign inval = hit && !trap_en;
  assign trap  = hit && trap_en;
  assign early = settled || inval;
endmodule

// File: rtl/fpm_special_stage.sv
module fpm_special_stage
  import fpm_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  parameter int XW = IEXP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EW+MW:0]       op_a,
  input  logic [EW+MW:0]       op_b,
  input  logic                 trap_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 res_sign,
  output logic                 early_valid,
  output logic [EW+MW:0]       early_res,
  output logic                 invalid,
  output logic                 trap_req,
  output logic [MW:0]          sig_a,
  output logic [MW:0]          sig_b,
  output logic signed [XW-1:0] res_exp
);
  localparam int WW   = EW + MW + 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [WW-1:0]        ops   [2];
  opclass_e             cls   [2];
  logic [MW:0]          nsig  [2];
  logic signed [XW-1:0] epart [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    fpm_classify #(.EW(EW), .MW(MW)) u_cls (
      .word (ops[g]),
      .cls  (cls[g])
    );
    fpm_subnorm #(.EW(EW), .MW(MW), .XW(XW)) u_norm (
      .ex_field (ops[g][WW-2:MW]),
      .frac     (ops[g][MW-1:0]),
      .sig      (nsig[g]),
      .ex_part  (epart[g])
    );
  end

  logic          sgn_c, early_c, inval_c, trap_c;
  logic [WW-1:0] res_c;
  logic signed [XW-1:0] exp_c;

  assign sgn_c = op_a[WW-1] ^ op_b[WW-1];
  assign exp_c = epart[0] + epart[1] - XW'(BIAS);

  fpm_decide #(.EW(EW), .MW(MW)) u_dec (
    .a       (op_a),
    .b       (op_b),
    .ca      (cls[0]),
    .cb      (cls[1]),
    .sgn     (sgn_c),
    .trap_en (trap_en),
    .early   (early_c),
    .res     (res_c),
    .inval   (inval_c),
    .trap    (trap_c)
  );

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_sign    <= 1'b0;
      early_valid <= 1'b0;
      early_res   <= '0;
      invalid     <= 1'b0;
      trap_req    <= 1'b0;
      sig_a       <= '0;
      sig_b       <= '0;
      res_exp     <= '0;
    end else if (take) begin
      res_sign    <= sgn_c;
      early_valid <= early_c;
      early_res   <= res_c;
      invalid     <= inval_c;
      trap_req    <= trap_c;
      sig_a       <= nsig[0];
      sig_b       <= nsig[1];
      res_exp     <= exp_c;
    end
  end
endmodule

// File: rtl/fpm_special_chk.sv
module fpm_special_chk #(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int XW = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 res_sign,
  input logic                 early_valid,
  input logic [EW+MW:0]       early_res,
  input logic                 invalid,
  input logic                 trap_req,
  input logic [MW:0]          sig_a,
  input logic [MW:0]          sig_b,
  input logic signed [XW-1:0] res_exp
);
  // R10: held output while stalled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(early_res) &&
      $stable(res_sign) && $stable(early_valid) && $stable(invalid) &&
      $stable(trap_req) && $stable(sig_a) && $stable(sig_b) && $stable(res_exp)));

  // R10: stalled stage refuses input
  a_r10_noaccept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11: empty stage accepts
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3: a trap never comes with a result or flag
  a_r3_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && trap_req) |-> (!early_valid && !invalid));

  // R2: an invalid flag always carries a quiet NaN
  a_r2_inv_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid) |-> (early_valid && early_res[EW+MW-1:MW] == '1 && early_res[MW-1]));

  // R8: finite path hands over normalized significands
  a_r8_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !early_valid && !trap_req) |-> (sig_a[MW] && sig_b[MW]));

  // R1: a settled non-NaN result carries the product sign
  a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && early_valid && !(early_res[EW+MW-1:MW] == '1 && early_res[MW-1:0] != '0))
      |-> (early_res[EW+MW] == res_sign));
endmodule

bind fpm_special_stage fpm_special_chk #(.EW(EW), .MW(MW), .XW(XW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .res_sign    (res_sign),
  .early_valid (early_valid),
  .early_res   (early_res),
  .invalid     (invalid),
  .trap_req    (trap_req),
  .sig_a       (sig_a),
  .sig_b       (sig_b),
  .res_exp     (res_exp)
);

// File: tb/sim_fpm_special_stage.sv
module sim_fpm_special_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic        trap_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        res_sign, early_valid, invalid, trap_req;
  logic [31:0] early_res;
  logic [23:0] sig_a, sig_b;
  logic signed [9:0] res_exp;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fpm_special_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .trap_en(trap_en), .out_valid(out_valid),
    .out_ready(out_ready), .res_sign(res_sign), .early_valid(early_valid),
    .early_res(early_res), .invalid(invalid), .trap_req(trap_req),
    .sig_a(sig_a), .sig_b(sig_b), .res_exp(res_exp)
  );

  function automatic bit w_nan(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit w_snan(logic [31:0] w);
    return w_nan(w) && !w[22];
  endfunction
  function automatic bit w_inf(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] == 0);
  endfunction
  function automatic bit w_zero(logic [31:0] w);
    return w[30:0] == 0;
  endfunction

  // reference significand and exponent share for one operand
  task automatic ref_norm(input logic [31:0] w, output logic [23:0] s, output int e);
    if (w[30:23] != 0) begin
      s = {1'b1, w[22:0]};
      e = int'(w[30:23]);
    end else begin
      s = {1'b0, w[22:0]};
      e = 1;
      while (!s[23] && s != 0) begin
        s = s << 1;
        e = e - 1;
      end
    end
  endtask

  // expected outputs and the requirement tag of the case
  task automatic ref_model(input logic [31:0] a, input logic [31:0] b, input bit te,
                           output bit xs, output bit xe, output logic [31:0] xr,
                           output bit xi, output bit xt, output logic [23:0] xsa,
                           output logic [23:0] xsb, output int xx, output string tag);
    bit bad;
    int ea, eb;
    bad = 0; xe = 0; xr = 0; tag = "R8";
    xs = a[31] ^ b[31];
    ref_norm(a, xsa, ea);
    ref_norm(b, xsb, eb);
    xx = ea + eb - 127;
    if (w_nan(a)) begin
      tag = "R5";
      if (w_snan(a)) begin bad = 1; xr = a | 32'h0040_0000; end
      else if (w_snan(b)) begin bad = 1; xr = b | 32'h0040_0000; end
      else begin xe = 1; xr = a; end
    end else if (w_nan(b)) begin
      tag = "R6";
      if (w_snan(b)) begin bad = 1; xr = b | 32'h0040_0000; end
      else begin xe = 1; xr = b; end
    end else if (w_inf(a) || w_inf(b)) begin
      if (w_zero(a) || w_zero(b)) begin
        tag = "R2"; bad = 1; xr = {xs, 31'h7FC0_0000};
      end else begin
        tag = "R4"; xe = 1; xr = {xs, 8'hFF, 23'h0};
      end
    end else if (w_zero(a) || w_zero(b)) begin
      tag = "R7"; xe = 1; xr = {xs, 31'h0};
    end else if (a[30:23] == 0 || b[30:23] == 0) begin
      tag = "R9";
    end
    xi = bad && !te;
    xt = bad && te;
    if (xi) xe = 1;
    if (xt) tag = "R3";
  endtask

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b, input bit te, input int hold);
    bit xs, xe, xi, xt;
    logic [31:0] xr;
    logic [23:0] xsa, xsb;
    int xx;
    string tag;
    bit ok;
    logic [31:0] kr;
    logic [9:0] kx;
    ref_model(a, b, te, xs, xe, xr, xi, xt, xsa, xsb, xx, tag);
    @(negedge clk);
    op_a = a; op_b = b; trap_en = te; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    ok = out_valid && (res_sign == xs) && (early_valid == xe) && (invalid == xi) &&
         (trap_req == xt);
    if (xe) ok = ok && (early_res == xr);
    if (!xe && !xt) ok = ok && (sig_a == xsa) && (sig_b == xsb) && (res_exp == 10'(xx));
    check(tag, ok,
      $sformatf("v%0d s%0d e%0d r%08h i%0d t%0d %06h %06h x%0d", out_valid, res_sign,
                early_valid, early_res, invalid, trap_req, sig_a, sig_b, res_exp),
      $sformatf("v1 s%0d e%0d r%08h i%0d t%0d %06h %06h x%0d", xs, xe, xr, xi, xt,
                xsa, xsb, xx));
    check("R1", res_sign == (a[31] ^ b[31]), $sformatf("%0d", res_sign),
          $sformatf("%0d", a[31] ^ b[31]));
    if (hold > 0) begin
      kr = early_res; kx = res_exp;
      repeat (hold) @(negedge clk);
      check("R10", out_valid && !in_ready && early_res == kr && res_exp == kx,
            $sformatf("v%0d rdy%0d %08h %0d", out_valid, in_ready, early_res, kx),
            $sformatf("v1 rdy0 %08h %0d", kr, kx));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R10", !out_valid && in_ready, $sformatf("v%0d rdy%0d", out_valid, in_ready), "v0 rdy1");
  endtask

  function automatic logic [31:0] mk(int cls);
    logic [31:0] w;
    logic [22:0] f;
    w = $urandom;
    f = w[22:0];
    case (cls)
      0: return {w[31], 31'h0};
      1: begin
        if (f == 0) f = 23'h1;
        if (w[24]) f = 23'h1 << (w[29:25] % 23);
        return {w[31], 8'h00, f};
      end
      2: return {w[31], 8'((w[30:23] % 8'd254) + 8'd1), f};
      3: return {w[31], 8'hFF, 23'h0};
      4: return {w[31], 8'hFF, 1'b1, f[21:0]};
      default: return {w[31], 8'hFF, 1'b0, (f[21:0] == 0) ? 22'h1 : f[21:0]};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R11", !out_valid && in_ready, $sformatf("v%0d rdy%0d", out_valid, in_ready), "v0 rdy1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", !out_valid && in_ready, $sformatf("v%0d rdy%0d", out_valid, in_ready), "v0 rdy1");

    // directed corners
    run_one(32'h7F80_0000, 32'h0000_0000, 1'b0, 0); // R2 inf*0
    run_one(32'h8000_0000, 32'h7F80_0000, 1'b0, 0); // R2 0*inf, negative
    run_one(32'h7F80_0000, 32'h8000_0000, 1'b1, 0); // R3 trapped
    run_one(32'hFF80_0000, 32'h3F80_0000, 1'b0, 0); // R4
    run_one(32'h7FC0_0001, 32'h7F80_0005, 1'b0, 0); // R5 quiet a, signaling b
    run_one(32'h7F80_0001, 32'h7F80_0002, 1'b1, 0); // R5 signaling a, trap
    run_one(32'hFFC1_2345, 32'h7FC0_0000, 1'b0, 0); // R5 both quiet
    run_one(32'h7F80_0000, 32'h7FA0_0000, 1'b0, 0); // R6 inf vs sNaN
    run_one(32'h4000_0000, 32'hFFC0_0007, 1'b0, 0); // R6 quiet b
    run_one(32'h0000_0000, 32'hC2F6_0000, 1'b0, 0); // R7
    run_one(32'h3F80_0000, 32'h3F80_0000, 1'b0, 2); // R8 1*1
    run_one(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 0); // R8 max exponent
    run_one(32'h0000_0001, 32'h0000_0001, 1'b0, 0); // R9 longest shift
    run_one(32'h0040_0000, 32'h0080_0000, 1'b0, 3); // R9 one-bit shift

    // class-driven random pairs
    for (int i = 0; i < 1500; i++) begin
      int ca, cb;
      ca = int'($urandom % 6);
      cb = int'($urandom % 6);
      run_one(mk(ca), mk(cb), 1'($urandom), int'($urandom % 3));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule